// File: doc/BRIEF.md
# Chroma hue and gain adjuster

This block is a pipelined arithmetic stage for a camera's colour path. Each clock it can take one pair of signed colour-difference samples, R-Y and B-Y. It rotates their hue by adding to each axis a weighted copy of the other axis. It then scales each axis by its own gain and clamps the results to the signed 8-bit range. The four coefficients come from host-written registers outside the block and are presented here as plain inputs.

The hue coefficients use sign-magnitude form, so a single byte can push an axis towards or away from the other one. The gain codes are unsigned. In a gain code, 0x20 means a gain of one, which lets the stage attenuate as well as amplify by up to about 18 dB. The block samples its coefficients together with each accepted sample. A register write that lands while samples are in flight therefore never splits one sample's arithmetic.

Top module: `chroma_hue_gain`

## Requirements
- R1: After reset, `out_vld` is 0 and both outputs are 0.
- R2: The stage accepts one sample pair per clock. When `in_vld` is high before clock edge k, `out_vld` is high after edge k+2 and at no other time for that sample.
- R3: A hue coefficient's bit 7 is the sign (1 selects subtraction) and bits 6:0 are a magnitude in units of 1/128. The hue term is floor((s·m·opp + 64) / 128), where s is ±1 and opp is the opposite-axis sample.
- R4: Corrected R-Y equals R-Y plus the hue term formed from `hue_ry` and B-Y.
- R5: Corrected B-Y equals B-Y plus the hue term formed from `hue_by` and R-Y.
- R6: A hue magnitude of 0 (code 0x00 or 0x80) leaves the axis unchanged before gain.
- R7: Each gain code is unsigned, with 0x20 meaning unity. The result is floor((corrected·code + 16) / 32).
- R8: A result above 127 leaves the block as 127, and a result below -128 leaves as -128. Results never wrap.
- R9: Coefficients are taken on the same edge as the sample they apply to. Values on the coefficient inputs in cycles without `in_vld`, and changes after a sample has been accepted, do not alter that sample's result.
- R10: While `out_vld` is 0, both outputs hold the last result that was delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Input sample pair is valid this cycle |
| in_ry | input | 8 | R-Y sample, two's complement |
| in_by | input | 8 | B-Y sample, two's complement |
| hue_ry | input | 8 | R-Y hue coefficient, sign-magnitude, weights B-Y |
| hue_by | input | 8 | B-Y hue coefficient, sign-magnitude, weights R-Y |
| gain_ry | input | 8 | R-Y gain code, 0x20 = unity |
| gain_by | input | 8 | B-Y gain code, 0x20 = unity |
| out_vld | output | 1 | Output pair is valid |
| out_ry | output | 8 | Adjusted R-Y, saturated two's complement |
| out_by | output | 8 | Adjusted B-Y, saturated two's complement |

## Verification
The hardest case to reach is a coefficient change that arrives while earlier samples are still in the pipeline. In that case the old coefficients must stay attached to the samples already accepted, and a result must still be checked after the outputs have idled. The bench reaches this by driving sparse, pseudo-random valid patterns. During idle cycles it puts unrelated values on every coefficient input, so any leak into the arithmetic shows up as a mismatch. The saturation extremes need large corrected values combined with high gain codes. To reach them, the bench sweeps every sample value against strong hue and gain settings, and separately sweeps every gain code against boundary samples.

// File: rtl/chg_pkg.sv
package chg_pkg;
  localparam int LANES   = 2;
  localparam int LANE_RY = 0;
  localparam int LANE_BY = 1;
endpackage

// File: rtl/chg_capture.sv
// Stage 1: samples and coefficients are registered together on an accepted sample.
module chg_capture
  import chg_pkg::*;
#(
  parameter int DW = 8,
  parameter int KW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      vld_i,
  input  logic [LANES-1:0][DW-1:0]  samp_i,
  input  logic [LANES-1:0][KW-1:0]  hue_i,
  input  logic [LANES-1:0][KW-1:0]  gain_i,
  output logic [LANES-1:0][DW-1:0]  samp_q,
  output logic [LANES-1:0][KW-1:0]  hue_q,
  output logic [LANES-1:0][KW-1:0]  gain_q
);
  logic [LANES-1:0][DW-1:0] samp_d;
  logic [LANES-1:0][KW-1:0] hue_d;
  logic [LANES-1:0][KW-1:0] gain_d;

  always_comb begin
    samp_d = samp_q;
    hue_d  = hue_q;
    gain_d = gain_q;
    if (vld_i) begin
      samp_d = samp_i;
      hue_d  = hue_i;
      gain_d = gain_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      hue_q  <= '0;
      gain_q <= '0;
    end else begin
      samp_q <= samp_d;
      hue_q  <= hue_d;
      gain_q <= gain_d;
    end
  end

  // R9: coefficients are frozen between accepted samples
  a_r9_coef_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> ($stable(hue_q) && $stable(gain_q)));
endmodule

// File: rtl/chg_hue_lane.sv
// Stage 2: one axis plus a sign-magnitude weighted copy of the other axis.
module chg_hue_lane #(
  parameter int DW = 8,
  parameter int KW = 8,
  parameter int CW = DW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld_i,
  input  logic signed [DW-1:0] own_i,
  input  logic signed [DW-1:0] opp_i,
  input  logic        [KW-1:0] hue_i,
  output logic signed [CW-1:0] corr_q
);
  localparam int MW     = KW - 1;
  localparam int PW     = DW + KW + 1;
  localparam int HALF_I = 1 << (MW - 1);

  logic signed [PW-1:0] mag_x, opp_x, prod, term_full, rnd, term;
  logic signed [CW-1:0] own_x, corr_d;

  always_comb begin
    mag_x     = {{(PW-MW){1'b0}}, hue_i[MW-1:0]};
    opp_x     = {{(PW-DW){opp_i[DW-1]}}, opp_i};
    prod      = mag_x * opp_x;
    term_full = hue_i[KW-1] ? -prod : prod;
    rnd       = term_full + PW'(HALF_I);
    term      = rnd >>> MW;
    own_x     = {{(CW-DW){own_i[DW-1]}}, own_i};
    corr_d    = corr_q;
    if (vld_i) corr_d = own_x + term[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) corr_q <= '0;
    else        corr_q <= corr_d;
  end

  // R6: zero magnitude passes the own axis through unchanged
  a_r6_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && hue_i[MW-1:0] == '0) |=> (corr_q == $past(own_x)));
endmodule

// File: rtl/chg_gain_lane.sv
// Stage 3: gain with a power-of-two unity code, rounding and saturation.
module chg_gain_lane #(
  parameter int DW = 8,
  parameter int KW = 8,
  parameter int CW = DW + 2,
  parameter int GF = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld_i,
  input  logic signed [CW-1:0] corr_i,
  input  logic        [KW-1:0] code_i,
  output logic signed [DW-1:0] q
);
  localparam int GW     = CW + KW + 1;
  localparam int QMAX   = (1 << (DW - 1)) - 1;
  localparam int QMIN   = -(1 << (DW - 1));
  localparam int HALF_I = 1 << (GF - 1);
  localparam int UNITY  = 1 << GF;
  localparam logic signed [GW-1:0] S_MAX = GW'(QMAX);
  localparam logic signed [GW-1:0] S_MIN = GW'(QMIN);
  localparam logic signed [CW-1:0] C_MAX = CW'(QMAX);
  localparam logic signed [CW-1:0] C_MIN = CW'(QMIN);
  localparam logic signed [DW-1:0] Q_MAX = DW'(QMAX);
  localparam logic signed [DW-1:0] Q_MIN = DW'(QMIN);

  logic signed [GW-1:0] corr_x, code_x, prod, rnd, shf;
  logic signed [DW-1:0] sat, q_d;

  always_comb begin
    corr_x = {{(GW-CW){corr_i[CW-1]}}, corr_i};
    code_x = {{(GW-KW){1'b0}}, code_i};
    prod   = corr_x * code_x;
    rnd    = prod + GW'(HALF_I);
    shf    = rnd >>> GF;
    if (shf > S_MAX)      sat = Q_MAX;
    else if (shf < S_MIN) sat = Q_MIN;
    else                  sat = shf[DW-1:0];
    q_d = vld_i ? sat : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  // R8: clamp at both ends
  a_r8_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && shf > S_MAX) |=> (q == Q_MAX));
  a_r8_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && shf < S_MIN) |=> (q == Q_MIN));
  // R7: unity code passes an in-range value unchanged
  a_r7_unity: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && code_i == KW'(UNITY) && corr_i <= C_MAX && corr_i >= C_MIN)
    |=> (q == $past(corr_i[DW-1:0])));
  // R10: output holds when nothing new arrives
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(q));
endmodule

// File: rtl/chroma_hue_gain.sv
module chroma_hue_gain
  import chg_pkg::*;
#(
  parameter int DW = 8,
  parameter int KW = 8,
  parameter int GF = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_ry,
  input  logic signed [DW-1:0] in_by,
  input  logic        [KW-1:0] hue_ry,
  input  logic        [KW-1:0] hue_by,
  input  logic        [KW-1:0] gain_ry,
  input  logic        [KW-1:0] gain_by,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_ry,
  output logic signed [DW-1:0] out_by
);
  localparam int CW    = DW + 2;
  localparam int DEPTH = 3;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q, rs_d;
  logic       rst_q;
  assign rs_d  = {rs_q[0], 1'b1};
  assign rst_q = rs_q[1];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end

  // valid pipeline
  logic [DEPTH-1:0] vp_q, vp_d;
  assign vp_d = {vp_q[DEPTH-2:0], in_vld};
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) vp_q <= '0;
    else        vp_q <= vp_d;
  end
  assign out_vld = vp_q[DEPTH-1];

  logic [LANES-1:0][DW-1:0] samp_in, samp_s1;
  logic [LANES-1:0][KW-1:0] hue_in, hue_s1, gain_in, gain_s1;
  logic signed [CW-1:0]     corr_s2 [LANES];
  logic signed [DW-1:0]     res_s3  [LANES];

  assign samp_in[LANE_RY] = in_ry;
  assign samp_in[LANE_BY] = in_by;
  assign hue_in[LANE_RY]  = hue_ry;
  assign hue_in[LANE_BY]  = hue_by;
  assign gain_in[LANE_RY] = gain_ry;
  assign gain_in[LANE_BY] = gain_by;

  chg_capture #(.DW(DW), .KW(KW)) u_cap (
    .clk(clk), .rst_n(rst_q), .vld_i(in_vld),
    .samp_i(samp_in), .hue_i(hue_in), .gain_i(gain_in),
    .samp_q(samp_s1), .hue_q(hue_s1), .gain_q(gain_s1)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    chg_hue_lane #(.DW(DW), .KW(KW), .CW(CW)) u_hue (
      .clk(clk), .rst_n(rst_q), .vld_i(vp_q[0]),
      .own_i($signed(samp_s1[i])), .opp_i($signed(samp_s1[LANES-1-i])),
      .hue_i(hue_s1[i]), .corr_q(corr_s2[i])
    );
    logic [KW-1:0] code_s2_q, code_s2_d;
    assign code_s2_d = vp_q[0] ? gain_s1[i] : code_s2_q;
    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) code_s2_q <= '0;
      else        code_s2_q <= code_s2_d;
    end
    chg_gain_lane #(.DW(DW), .KW(KW), .CW(CW), .GF(GF)) u_gain (
      .clk(clk), .rst_n(rst_q), .vld_i(vp_q[1]),
      .corr_i(corr_s2[i]), .code_i(code_s2_q), .q(res_s3[i])
    );
  end

  assign out_ry = res_s3[LANE_RY];
  assign out_by = res_s3[LANE_BY];

  // R2: fixed three-clock latency in both directions
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_q)
    in_vld |=> ##2 out_vld);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_q)
    !in_vld |=> ##2 !out_vld);
endmodule

// File: tb/chroma_hue_gain_test.sv
`timescale 1ns/1ps
module chroma_hue_gain_test;
  logic clk = 1'b0;
  logic rst_n;
  logic in_vld;
  logic signed [7:0] in_ry, in_by;
  logic [7:0] hue_ry, hue_by, gain_ry, gain_by;
  logic out_vld;
  logic signed [7:0] out_ry, out_by;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  chroma_hue_gain uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ry(in_ry), .in_by(in_by),
    .hue_ry(hue_ry), .hue_by(hue_by), .gain_ry(gain_ry), .gain_by(gain_by),
    .out_vld(out_vld), .out_ry(out_ry), .out_by(out_by)
  );

  // expected-value arithmetic taken from the requirements
  function automatic int hue_ref(int own, int opp, int c);
    int t;
    t = (c & 127) * opp;
    if ((c & 128) != 0) t = -t;
    return own + ((t + 64) >>> 7);
  endfunction

  function automatic int gain_ref(int x, int code);
    int r;
    r = (x * code + 16) >>> 5;
    if (r > 127)  r = 127;
    if (r < -128) r = -128;
    return r;
  endfunction

  bit    pv [3];
  int    pr [3];
  int    pb [3];
  string pt [3];
  int    last_r = 0;
  int    last_b = 0;

  task automatic chk(input bit ok, input string tag, input int ar, input int ab,
                     input int er, input int eb);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d/%0d expected %0d/%0d", tag, ar, ab, er, eb);
    end
  endtask

  task automatic cyc(input bit v, input int ry, input int by, input int hr,
                     input int hb, input int gr, input int gb, input string tag);
    int er, eb;
    in_vld  = v;
    in_ry   = 8'(ry);
    in_by   = 8'(by);
    hue_ry  = 8'(hr);
    hue_by  = 8'(hb);
    gain_ry = 8'(gr);
    gain_by = 8'(gb);
    er = gain_ref(hue_ref(ry, by, hr), gr);
    eb = gain_ref(hue_ref(by, ry, hb), gb);
    @(posedge clk);
    for (int k = 2; k > 0; k--) begin
      pv[k] = pv[k-1]; pr[k] = pr[k-1]; pb[k] = pb[k-1]; pt[k] = pt[k-1];
    end
    pv[0] = v; pr[0] = er; pb[0] = eb; pt[0] = tag;
    @(negedge clk);
    if (pv[2]) begin
      chk(out_vld == 1'b1, {"R2 valid ", pt[2]}, int'(out_vld), 0, 1, 0);
      chk(int'(out_ry) == pr[2] && int'(out_by) == pb[2], pt[2],
          int'(out_ry), int'(out_by), pr[2], pb[2]);
      last_r = pr[2];
      last_b = pb[2];
    end else begin
      chk(out_vld == 1'b0, {"R2 idle ", pt[2]}, int'(out_vld), 0, 0, 0);
      chk(int'(out_ry) == last_r && int'(out_by) == last_b, {"R10 hold ", pt[2]},
          int'(out_ry), int'(out_by), last_r, last_b);
    end
  endtask

  task automatic flush(input string tag);
    for (int k = 0; k < 4; k++) cyc(1'b0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    int sets [4][4];
    int corner [8];
    for (int k = 0; k < 3; k++) begin pv[k] = 1'b0; pr[k] = 0; pb[k] = 0; pt[k] = "R10"; end
    rst_n = 1'b0; in_vld = 1'b0; in_ry = '0; in_by = '0;
    hue_ry = '0; hue_by = '0; gain_ry = '0; gain_by = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_vld == 1'b0 && out_ry == 8'sd0 && out_by == 8'sd0, "R1 reset",
        int'(out_vld), int'(out_ry), 0, 0);

    // R6 R7: zero hue magnitude (both sign codes) and unity gain give identity
    for (int s = 0; s < 2; s++)
      for (int r = -128; r < 128; r++)
        for (int b = -128; b < 128; b += 16)
          cyc(1'b1, r, b, s * 128, s * 128, 32, 32, "R6 R7 identity");
    flush("R10");

    // R3 R4 / R3 R5: every hue code against boundary samples
    corner = '{-128, 127, 100, -37, 1, -1, 0, 64};
    for (int c = 0; c < 256; c++)
      for (int k = 0; k < 4; k++)
        cyc(1'b1, corner[k], corner[7-k], c, 0, 32, 32, "R3 R4 ry hue");
    for (int c = 0; c < 256; c++)
      for (int k = 0; k < 4; k++)
        cyc(1'b1, corner[k+4], corner[k], 0, c, 32, 32, "R3 R5 by hue");
    flush("R10");

    // R7 R8: every gain code against boundary samples, with saturation
    for (int g = 0; g < 256; g++)
      for (int k = 0; k < 8; k++)
        cyc(1'b1, corner[k], corner[7-k], 127, 255, g, 255 - g, "R7 R8 gain");
    flush("R10");

    // R3 R4 R5 R8: dense sweep under mixed coefficient sets
    sets = '{'{127, 255, 255, 255}, '{192, 37, 16, 71},
             '{51, 192, 32, 0}, '{255, 127, 1, 153}};
    for (int s = 0; s < 4; s++)
      for (int r = -128; r < 128; r++)
        for (int b = -128; b < 128; b += 8)
          cyc(1'b1, r, b, sets[s][0], sets[s][1], sets[s][2], sets[s][3], "R4 R5 R8 sweep");
    flush("R10");

    // R2 R9 R10: sparse valid, unrelated coefficients on idle cycles
    lf = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0] & lf[5], int'($signed(lf[15:8])), int'($signed(lf[7:0])),
          int'(lf[11:4]), int'(lf[13:6]), int'(lf[9:2]), int'(lf[15:8]),
          "R2 R9 R10 sparse");
    end
    flush("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule